// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block computes the eight integer multiply and divide operations of a 32-bit RISC-style core on two register operands. The operation code and both operands are presented together with a one-cycle start pulse. The unit then works on its own for a fixed number of cycles and raises a one-cycle done pulse when the 32-bit result is ready. Multiplication uses one wide multiplier stage. Division uses a restoring shift-subtract loop that retires one quotient bit per cycle.

Signed operands are first reduced to magnitudes. The core arithmetic then runs unsigned, and a final cycle restores the sign of the product, quotient or remainder. Divide-by-zero and the single signed-overflow case produce fixed results instead of traps. While the unit is busy, new start pulses are dropped. The result register keeps its value until the next operation completes.

Top module: `muldiv_unit`

## Requirements
- R1: Code 0 (`op_i`=3'd0) returns the low 32 bits of the product `a_i`×`b_i`.
- R2: Code 1 returns the high 32 bits of the 64-bit product, with both operands taken as two's-complement signed.
- R3: Code 3 returns the high 32 bits of the product, with both operands taken as unsigned.
- R4: Code 2 returns the high 32 bits of the product, with `a_i` signed and `b_i` unsigned.
- R5: Code 4 (signed) and code 5 (unsigned) return the quotient `a_i`/`b_i`. The signed quotient is truncated toward zero.
- R6: Code 6 (signed) and code 7 (unsigned) return the remainder. A signed remainder carries the sign of the dividend, so that dividend = quotient×divisor + remainder.
- R7: A divisor of zero makes codes 4 and 5 return 32'hFFFFFFFF and codes 6 and 7 return `a_i` unchanged.
- R8: Code 4 with `a_i`=32'h80000000 and `b_i`=32'hFFFFFFFF returns 32'h80000000. Code 6 with the same operands returns 0.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The running operation finishes with its original operands, and no extra done pulse follows.
- R10: `done_o` is high for exactly one cycle per operation. `result_o` changes only in a cycle where `done_o` is high.
- R11: Counting from the clock edge that accepts start, `done_o` rises on the 3rd edge for codes 0–3 and on the 34th edge for codes 4–7. The division path uses 1 setup cycle, 32 quotient-bit cycles and 1 sign fixup cycle.
- R12: After reset, `busy_o`, `done_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request; taken only while idle |
| op_i | input | 3 | 0 mul, 1 mul-high s×s, 2 mul-high s×u, 3 mul-high u×u, 4 div, 5 div unsigned, 6 rem, 7 rem unsigned |
| a_i | input | 32 | First operand / dividend |
| b_i | input | 32 | Second operand / divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: result_o updated |
| result_o | output | 32 | Result of the last completed operation |

## Verification
Some rules can be checked on every cycle, and the assertions cover them:
- the done pulse lasts one cycle, and the result is held between pulses;
- done never coincides with busy;
- once accepted, busy stays high until done;
- the 3-cycle and 34-cycle latencies hold;
- divide-by-zero gives a quotient of all ones;
- the overflow case gives the most negative quotient.

The arithmetic is too broad for cycle-level properties. Products in the three signedness mixes, quotients truncated toward zero, and remainder signs are shown only by the bench's scoreboard, using directed corner operands and a stream of random ones. The same holds for the proof that a start pulse during a division changes neither the outcome nor the number of done pulses.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULH   = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHU  = 3'd3,
    OP_DIV    = 3'd4,
    OP_DIVU   = 3'd5,
    OP_REM    = 3'd6,
    OP_REMU   = 3'd7
  } md_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_MULT,
    ST_DIVI,
    ST_FIX
  } md_state_e;

  function automatic logic op_is_div(input md_op_e op);
    return op[2];
  endfunction

  function automatic logic op_a_signed(input md_op_e op);
    return (op == OP_MUL) || (op == OP_MULH) || (op == OP_MULHSU) ||
           (op == OP_DIV) || (op == OP_REM);
  endfunction

  function automatic logic op_b_signed(input md_op_e op);
    return (op == OP_MUL) || (op == OP_MULH) ||
           (op == OP_DIV) || (op == OP_REM);
  endfunction

  function automatic logic op_wants_rem(input md_op_e op);
    return (op == OP_REM) || (op == OP_REMU);
  endfunction

endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep
  import muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  md_op_e         op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   mag_a_o,
  output logic [W-1:0]   mag_b_o,
  output logic           neg_prod_o,
  output logic           neg_quot_o,
  output logic           neg_rem_o
);

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic is_neg);
    return is_neg ? (~v + 1'b1) : v;
  endfunction

  logic a_neg_w;
  logic b_neg_w;
  logic b_zero_w;

  assign a_neg_w  = op_a_signed(op_i) && a_i[W-1];
  assign b_neg_w  = op_b_signed(op_i) && b_i[W-1];
  assign b_zero_w = (b_i == '0);

  assign mag_a_o    = magnitude(a_i, a_neg_w);
  assign mag_b_o    = magnitude(b_i, b_neg_w);
  assign neg_prod_o = a_neg_w ^ b_neg_w;
  // a zero divisor keeps the all-ones quotient unsigned-looking
  assign neg_quot_o = (a_neg_w ^ b_neg_w) && !b_zero_w;
  assign neg_rem_o  = a_neg_w;

endmodule

// File: rtl/muldiv_mult.sv
module muldiv_mult #(
  parameter int unsigned W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [W-1:0]     x_i,
  input  logic [W-1:0]     y_i,
  output logic [2*W-1:0]   prod_o
);

  localparam int unsigned PW = 2 * W;

  function automatic logic [PW-1:0] wide_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    return {{W{1'b0}}, x} * {{W{1'b0}}, y};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_o <= '0;
    end else if (en_i) begin
      prod_o <= wide_mul(x_i, y_i);
    end
  end

endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   dividend_i,
  input  logic [W-1:0]   divisor_i,
  output logic [W-1:0]   quot_o,
  output logic [W-1:0]   rem_o,
  output logic           last_o
);

  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  // one restoring iteration: shift in next dividend bit, try subtract
  function automatic logic [2*W-1:0] restore_step(input logic [W-1:0] p,
                                                  input logic [W-1:0] q,
                                                  input logic [W-1:0] d);
    logic [W:0]   shifted;
    logic [W:0]   trial;
    logic [W-1:0] p_next;
    logic         qbit;
    shifted = {p, q[W-1]};
    trial   = shifted - {1'b0, d};
    qbit    = !trial[W];
    p_next  = qbit ? trial[W-1:0] : shifted[W-1:0];
    return {p_next, q[W-2:0], qbit};
  endfunction

  logic [W-1:0]  part_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dsr_q;
  logic [CW-1:0] cnt_q;
  logic [2*W-1:0] step_w;

  assign step_w = restore_step(part_q, quo_q, dsr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      part_q <= '0;
      quo_q  <= dividend_i;
      dsr_q  <= divisor_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      part_q <= step_w[2*W-1:W];
      quo_q  <= step_w[W-1:0];
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign last_o = step_i && (cnt_q == LAST_CNT);
  assign quot_o = quo_q;
  assign rem_o  = part_q;

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [2:0]     op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [W-1:0]   result_o
);

  localparam int unsigned PW = 2 * W;

  function automatic logic [W-1:0] finish_value(input md_op_e         op,
                                                input logic [PW-1:0] prod,
                                                input logic          neg_p,
                                                input logic [W-1:0]  quot,
                                                input logic [W-1:0]  rem,
                                                input logic          neg_q,
                                                input logic          neg_r);
    logic [PW-1:0] prod_s;
    logic [W-1:0]  quot_s;
    logic [W-1:0]  rem_s;
    prod_s = neg_p ? (~prod + 1'b1) : prod;
    quot_s = neg_q ? (~quot + 1'b1) : quot;
    rem_s  = neg_r ? (~rem + 1'b1) : rem;
    if (op_is_div(op)) begin
      return op_wants_rem(op) ? rem_s : quot_s;
    end
    return (op == OP_MUL) ? prod_s[W-1:0] : prod_s[PW-1:W];
  endfunction

  md_state_e     state_q, state_d;
  md_op_e        op_q;
  logic [W-1:0]  a_q, b_q;
  logic [W-1:0]  result_q;
  logic          done_q;

  // named internal events
  logic          accept_w;
  logic          div_load_w;
  logic          div_step_w;
  logic          div_last_w;
  logic          mul_en_w;
  logic          fix_w;

  logic [W-1:0]  mag_a_w, mag_b_w;
  logic          neg_prod_w, neg_quot_w, neg_rem_w;
  logic [PW-1:0] prod_w;
  logic [W-1:0]  quot_w, rem_w;

  assign accept_w   = start_i && (state_q == ST_IDLE);
  assign div_load_w = (state_q == ST_SETUP);
  assign div_step_w = (state_q == ST_DIVI);
  assign mul_en_w   = (state_q == ST_MULT);
  assign fix_w      = (state_q == ST_FIX);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_w) state_d = ST_SETUP;
      ST_SETUP: state_d = op_is_div(op_q) ? ST_DIVI : ST_MULT;
      ST_MULT:  state_d = ST_FIX;
      ST_DIVI:  if (div_last_w) state_d = ST_FIX;
      ST_FIX:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_MUL;
      a_q      <= '0;
      b_q      <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fix_w;
      if (accept_w) begin
        op_q <= md_op_e'(op_i);
        a_q  <= a_i;
        b_q  <= b_i;
      end
      if (fix_w) begin
        result_q <= finish_value(op_q, prod_w, neg_prod_w, quot_w, rem_w,
                                 neg_quot_w, neg_rem_w);
      end
    end
  end

  muldiv_prep #(.W(W)) u_prep (
    .op_i       (op_q),
    .a_i        (a_q),
    .b_i        (b_q),
    .mag_a_o    (mag_a_w),
    .mag_b_o    (mag_b_w),
    .neg_prod_o (neg_prod_w),
    .neg_quot_o (neg_quot_w),
    .neg_rem_o  (neg_rem_w)
  );

  muldiv_mult #(.W(W)) u_mult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mul_en_w),
    .x_i    (mag_a_w),
    .y_i    (mag_b_w),
    .prod_o (prod_w)
  );

  muldiv_div #(.W(W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (div_load_w),
    .step_i     (div_step_w),
    .dividend_i (mag_a_w),
    .divisor_i  (mag_b_w),
    .quot_o     (quot_w),
    .rem_o      (rem_w),
    .last_o     (div_last_w)
  );

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int unsigned W = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [2:0]     op_i,
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   b_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [W-1:0]   result_o
);

  localparam int unsigned LW = $clog2(W + 4) + 1;
  localparam logic [LW-1:0] MUL_LAT = LW'(3);
  localparam logic [LW-1:0] DIV_LAT = LW'(W + 2);
  localparam logic [W-1:0]  MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [LW-1:0] lat_q;
  logic [2:0]    cap_op_q;
  logic [W-1:0]  cap_a_q, cap_b_q;
  logic          take_w;

  assign take_w = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q    <= '0;
      cap_op_q <= '0;
      cap_a_q  <= '0;
      cap_b_q  <= '0;
    end else if (take_w) begin
      lat_q    <= '0;
      cap_op_q <= op_i;
      cap_a_q  <= a_i;
      cap_b_q  <= b_i;
    end else if (busy_o && (lat_q != '1)) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  // R12
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  busy_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  // R9
  take_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_w |=> busy_o);

  // R11
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == (cap_op_q[2] ? DIV_LAT : MUL_LAT)));

  // R7
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_op_q[2] && !cap_op_q[1] && (cap_b_q == '0)) |-> (result_o == '1));

  // R8
  div_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (cap_op_q == 3'd4) && (cap_a_q == MOST_NEG) && (cap_b_q == '1))
      |-> (result_o == MOST_NEG));

endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/muldiv_unit_bench.sv
`timescale 1ns/1ps
module muldiv_unit_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        busy_o;
  logic        done_o;
  logic [31:0] result_o;

  int unsigned cyc = 0;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          finished = 1'b0;
  logic        prev_done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    int unsigned start_cyc;
    int unsigned lat;
    string       tag;
  } item_t;

  item_t sb_q[$];

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  muldiv_unit u_muldiv_unit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic logic [31:0] ref_result(input logic [2:0] op, input logic [31:0] a,
                                             input logic [31:0] b);
    logic [63:0] sa, sb, ua, ub;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    ua = {32'd0, a};
    ub = {32'd0, b};
    case (op)
      3'd0: ref_result = 32'((sa * sb) & 64'hFFFF_FFFF);
      3'd1: ref_result = 32'((sa * sb) >> 32);
      3'd2: ref_result = 32'((sa * ub) >> 32);
      3'd3: ref_result = 32'((ua * ub) >> 32);
      3'd4: if (b == 0) ref_result = 32'hFFFF_FFFF;
            else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) ref_result = a;
            else ref_result = $signed(a) / $signed(b);
      3'd5: ref_result = (b == 0) ? 32'hFFFF_FFFF : a / b;
      3'd6: if (b == 0) ref_result = a;
            else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) ref_result = 0;
            else ref_result = $signed(a) % $signed(b);
      default: ref_result = (b == 0) ? a : a % b;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic [31:0] a,
                                   input logic [31:0] b);
    if (op[2] && b == 0) return "R7";
    if ((op == 3'd4 || op == 3'd6) && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R8";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R3";
      3'd4, 3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  // driver: pushes the expected item, pulses start, optionally pokes while busy
  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input bit poke, input string force_tag);
    item_t it;
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    it.exp = ref_result(op, a, b);
    it.lat = op[2] ? 34 : 3;
    it.tag = (force_tag != "") ? force_tag : tag_of(op, a, b);
    @(posedge clk_i);
    #1;
    it.start_cyc = cyc;
    sb_q.push_back(it);
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk_i);
      start_i = 1'b1; op_i = 3'd0; a_i = 32'd9; b_i = 32'd9;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk_i);
  endtask

  // monitor: compares results and latency as they appear
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_done) check(!done_o, "R10 done width", {31'd0, done_o}, 32'd0);
      if (done_o) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R9 unexpected done", result_o, 32'd0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          check(result_o == it.exp, it.tag, result_o, it.exp);
          check((cyc - it.start_cyc) == it.lat, "R11 latency",
                32'(cyc - it.start_cyc), 32'(it.lat));
        end
      end
    end
    prev_done <= done_o;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R12 reset state
    check(busy_o == 1'b0, "R12 busy", {31'd0, busy_o}, 32'd0);
    check(done_o == 1'b0, "R12 done", {31'd0, done_o}, 32'd0);
    check(result_o == 32'd0, "R12 result", result_o, 32'd0);
    rst_ni = 1'b1;

    // R1 low product
    issue(3'd0, 32'd7, 32'd6, 0, "");
    issue(3'd0, 32'hFFFF_FFFD, 32'd5, 0, "");
    // R2 signed high product
    issue(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "");
    issue(3'd1, 32'h8000_0000, 32'h8000_0000, 0, "");
    issue(3'd1, 32'hFFFF_FFFE, 32'd3, 0, "");
    // R3 unsigned high product
    issue(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "");
    // R4 mixed-sign high product
    issue(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "");
    issue(3'd2, 32'h7FFF_FFFF, 32'h8000_0000, 0, "");
    // R5 quotients
    issue(3'd4, 32'hFFFF_FFF9, 32'd2, 0, "");
    issue(3'd4, 32'd7, 32'hFFFF_FFFE, 0, "");
    issue(3'd5, 32'hFFFF_FFF9, 32'd2, 0, "");
    // R6 remainders
    issue(3'd6, 32'hFFFF_FFF9, 32'd2, 0, "");
    issue(3'd6, 32'd7, 32'hFFFF_FFFE, 0, "");
    issue(3'd7, 32'hFFFF_FFF9, 32'd10, 0, "");
    // R7 zero divisor
    issue(3'd4, 32'hFFFF_FF00, 32'd0, 0, "");
    issue(3'd5, 32'd1234, 32'd0, 0, "");
    issue(3'd6, 32'hFFFF_FF00, 32'd0, 0, "");
    issue(3'd7, 32'd1234, 32'd0, 0, "");
    // R8 signed overflow
    issue(3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 0, "");
    issue(3'd6, 32'h8000_0000, 32'hFFFF_FFFF, 0, "");

    // mixed random patterns over all codes
    for (int i = 0; i < 64; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = (i % 5 == 0) ? ($urandom & 32'h0000_00FF) : $urandom;
      issue(3'(i % 8), ra, rb, 0, "");
    end

    // R9 start while busy is ignored
    issue(3'd5, 32'd1000, 32'd7, 1, "R9");
    repeat (40) @(negedge clk_i);
    check(sb_q.size() == 0 && !busy_o, "R9 no restart", {31'd0, busy_o}, 32'd0);

    // R10 result held after done
    issue(3'd0, 32'd11, 32'd13, 0, "");
    @(negedge clk_i);
    held = result_o;
    repeat (10) @(negedge clk_i);
    check(result_o == held && result_o == 32'd143, "R10 hold", result_o, 32'd143);

    repeat (5) @(negedge clk_i);
    check(sb_q.size() == 0, "R10 scoreboard drained", 32'(sb_q.size()), 32'd0);
    finish_run();
  end

endmodule